// File: doc/BRIEF.md
# H-Bridge PWM Voltage Regulator

This block generates the four FET enables of one H-bridge. Two direction bits select one of four states: coast, forward, reverse or brake. In forward and reverse, a pulse-width modulated duty cycle sets the average voltage across the load. A digital comparator flag reports whether the averaged bridge voltage, scaled down by four, lies below the 6-bit setpoint. The duty moves up or down by one count on each regulation step, so the bridge holds a constant load voltage while the supply drifts.

Each time the bridge enters a driving state, the duty starts again at zero and climbs step by step. An external current-limit flag overrides the comparator and pulls the duty down. A fault-disable input switches every FET off without waiting for a clock edge. During the off-time of each PWM period, current recirculates through both high-side FETs. The present duty is available as a status word. The comparator, the DAC, the reference and the gate drivers sit outside the block and appear only as flags.

Top module: `hbridge_vreg`

## Requirements
- R1: With dir_a=0 and dir_b=0 (coast), all four enables are low and `standby` is high. On the next clock the duty reads 0.
- R2: In forward (dir_a=1, dir_b=0), the on-time drives hs1 and ls2. In reverse (dir_a=0, dir_b=1), the on-time drives hs2 and ls1.
- R3: In brake (dir_a=1, dir_b=1), hs1 and hs2 are high, ls1 and ls2 are low, and the duty is held at 0.
- R4: During the off-time in forward or reverse, hs1 and hs2 are both high and both low-side enables are low. No side ever has its high-side and low-side enables on together.
- R5: While driving with a valid setpoint, the duty changes once every STEP_CYCLES clocks. It rises by 1 when `fb_below` is high and falls by 1 when `fb_below` is low, and it saturates at 0 and at 255.
- R6: On entry into forward or reverse from coast or brake, the duty starts at 0. After N clocks in the driving state with `fb_below` high, it equals floor(N/STEP_CYCLES).
- R7: At duty 255 the bridge stays in the on-time state every clock, which gives 100 % duty.
- R8: A setpoint code of 0 to 5 forces the duty to 0, so the bridge stays in the off-time state.
- R9: While `ilim` is high, each regulation step lowers the duty by 1 even when `fb_below` is high.
- R10: While `kill` is high, all four enables are low in the same cycle.
- R11: The PWM period is 256×PRESCALE clocks. Within any whole period at a constant duty D below 255, the on-time lasts D×PRESCALE clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_a | input | 1 | Direction bit; 1 drives OUT1 high |
| dir_b | input | 1 | Direction bit; 1 drives OUT2 high |
| vset | input | 6 | Voltage setpoint code |
| fb_below | input | 1 | Comparator: scaled average below setpoint |
| ilim | input | 1 | Current-limit flag |
| kill | input | 1 | Fault disable; forces all FETs off |
| hs1 | output | 1 | OUT1 high-side enable |
| ls1 | output | 1 | OUT1 low-side enable |
| hs2 | output | 1 | OUT2 high-side enable |
| ls2 | output | 1 | OUT2 low-side enable |
| duty | output | 8 | Present duty cycle |
| standby | output | 1 | High in coast (low-power) state |

## Verification
The assertions assume that `fb_below` and `ilim` are synchronous flags that change only between clock edges. They also assume that the direction bits and `vset` hold steady for at least one clock when they change. The bench drives every input on the falling edge. It holds each pattern for whole multiples of the regulation step, so the expected duty follows from counting edges alone. It runs with a short step and a prescale of 1, so the ramp reaches saturation within the run.

// File: rtl/hbridge_vreg.sv
`timescale 1ns/1ps
module hbridge_vreg #(
  parameter int DUTY_W      = 8,
  parameter int VSET_W      = 6,
  parameter int RSV_MAX     = 5,
  parameter int PRESCALE    = 4,
  parameter int STEP_CYCLES = 2353
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_a,
  input  logic              dir_b,
  input  logic [VSET_W-1:0] vset,
  input  logic              fb_below,
  input  logic              ilim,
  input  logic              kill,
  output logic              hs1,
  output logic              ls1,
  output logic              hs2,
  output logic              ls2,
  output logic [DUTY_W-1:0] duty,
  output logic              standby
);
  localparam int PRE_W  = $clog2(PRESCALE + 1);
  localparam int STEP_W = $clog2(STEP_CYCLES + 1);
  localparam logic [DUTY_W-1:0] DUTY_MAX = {DUTY_W{1'b1}};

  logic [PRE_W-1:0]  pre;
  logic [DUTY_W-1:0] pwm;
  logic [STEP_W-1:0] step;
  logic drive, code_ok, run, tick, on;

  assign drive   = dir_a ^ dir_b;
  assign code_ok = vset > VSET_W'(RSV_MAX);
  assign run     = drive & code_ok;
  assign tick    = run && (step == STEP_W'(STEP_CYCLES - 1));
  assign on      = (duty == DUTY_MAX) || (pwm < duty);
  assign standby = ~dir_a & ~dir_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      pwm <= '0;
    end else if (pre == PRE_W'(PRESCALE - 1)) begin
      pre <= '0;
      pwm <= pwm + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) step <= '0;
    else                        step <= step + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      duty <= '0;
    end else if (tick) begin
      if (ilim || !fb_below) begin
        if (duty != '0) duty <= duty - 1'b1;
      end else if (duty != DUTY_MAX) begin
        duty <= duty + 1'b1;
      end
    end
  end

  always_comb begin
    {hs1, ls1, hs2, ls2} = 4'b0000;
    if (!kill) begin
      unique case ({dir_a, dir_b})
        2'b10: begin
          hs1 = 1'b1;
          if (on) ls2 = 1'b1;
          else    hs2 = 1'b1;
        end
        2'b01: begin
          hs2 = 1'b1;
          if (on) ls1 = 1'b1;
          else    hs1 = 1'b1;
        end
        2'b11: begin
          hs1 = 1'b1;
          hs2 = 1'b1;
        end
        default: ;
      endcase
    end
  end

  a_r10_kill_off: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> !(hs1 || ls1 || hs2 || ls2));
  a_r4_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs1 && ls1) && !(hs2 && ls2));
  a_r1_coast_off: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !(hs1 || ls1 || hs2 || ls2));
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> duty == '0);
  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (duty == $past(duty) || duty == $past(duty) + 1'b1 || duty + 1'b1 == $past(duty)));
  a_r9_ilim_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ilim && duty != '0) |=> duty < $past(duty));
  a_r7_full_on: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_a && !dir_b && !kill && duty == DUTY_MAX) |-> (ls2 && !hs2));
endmodule

// File: tb/hbridge_vreg_tb.sv
`timescale 1ns/1ps
module hbridge_vreg_tb;
  localparam int STEP = 320;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_a = 1'b0, dir_b = 1'b0, fb_below = 1'b0, ilim = 1'b0, kill = 1'b0;
  logic [5:0] vset = 6'd0;
  logic hs1, ls1, hs2, ls2, standby;
  logic [7:0] duty;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hbridge_vreg #(.PRESCALE(1), .STEP_CYCLES(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b), .vset(vset),
    .fb_below(fb_below), .ilim(ilim), .kill(kill),
    .hs1(hs1), .ls1(ls1), .hs2(hs2), .ls2(ls2), .duty(duty), .standby(standby));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int gates();
    return {hs1, ls1, hs2, ls2};
  endfunction

  task automatic t_reset;
    chk("R1 reset duty", duty, 0);
    chk("R1 reset gates", gates(), 0);
    chk("R1 reset standby", standby, 1);
  endtask

  task automatic t_reserved;
    int on_cnt = 0;
    dir_a = 1; dir_b = 0; vset = 6'd5; fb_below = 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (ls2) on_cnt++;
    end
    chk("R8 reserved duty", duty, 0);
    chk("R8 reserved no on-time", on_cnt, 0);
    chk("R8 off-time gates", gates(), 4'b1010);
  endtask

  task automatic t_coast;
    dir_a = 0; dir_b = 0;
    #1;
    chk("R1 coast gates", gates(), 0);
    chk("R1 coast standby", standby, 1);
    edges(1);
    chk("R1 coast duty", duty, 0);
  endtask

  task automatic t_ramp;
    int on_cnt = 0, off_cnt = 0, full = 0;
    dir_a = 1; dir_b = 0; vset = 6'h20; fb_below = 1;
    #1;
    chk("R6 start duty", duty, 0);
    edges(STEP - 1);
    chk("R6 before first step", duty, 0);
    edges(1);
    chk("R6 first step", duty, 1);
    edges(39 * STEP);
    chk("R5 ramp duty 40", duty, 40);
    for (int i = 0; i < 256; i++) begin
      if (ls2 && hs1 && !hs2) on_cnt++;
      if (hs1 && hs2 && !ls1 && !ls2) off_cnt++;
      @(negedge clk);
    end
    chk("R11 on-time per period", on_cnt, 40);
    chk("R4 recirculation per period", off_cnt, 216);
    edges(255 * STEP - 40 * STEP - 256);
    chk("R5 saturate 255", duty, 255);
    edges(STEP);
    chk("R5 stays 255", duty, 255);
    for (int i = 0; i < 300; i++) begin
      if (ls2 && hs1) full++;
      @(negedge clk);
    end
    chk("R7 full on", full, 300);
  endtask

  task automatic t_reverse;
    dir_a = 0; dir_b = 1;
    #1;
    chk("R2 reverse gates", gates(), 4'b0110);
    edges(1);
    chk("R2 reverse keeps duty", duty, 255);
    dir_a = 1; dir_b = 0;
    #1;
    chk("R2 forward gates", gates(), 4'b1001);
  endtask

  task automatic t_kill;
    @(negedge clk);
    kill = 1;
    #1;
    chk("R10 kill gates", gates(), 0);
    edges(3);
    chk("R10 kill held", gates(), 0);
    kill = 0;
    #1;
    chk("R10 release", gates(), 4'b1001);
  endtask

  task automatic t_ilim;
    @(negedge clk);
    ilim = 1; fb_below = 1;
    edges(2 * STEP);
    chk("R9 ilim overrides", duty, 253);
    ilim = 0; fb_below = 0;
    edges(3 * STEP);
    chk("R5 step down", duty, 250);
  endtask

  task automatic t_brake;
    dir_a = 1; dir_b = 1; fb_below = 1;
    #1;
    chk("R3 brake gates", gates(), 4'b1010);
    edges(1);
    chk("R3 brake duty", duty, 0);
    edges(5);
    dir_a = 1; dir_b = 0;
    edges(STEP);
    chk("R6 restart after brake", duty, 1);
    dir_a = 0; dir_b = 0;
    edges(1);
  endtask

  initial begin
    edges(3);
    rst_n = 1;
    edges(1);
    t_reset();
    t_reserved();
    t_coast();
    t_ramp();
    t_reverse();
    t_kill();
    t_ilim();
    t_brake();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule